// File: doc/BRIEF.md
# Receive Cipher Lock and Jabber Guard

This block sits beside the receive descrambler of a 100 Mb/s twisted-pair physical layer. It watches the stream of decoded receive symbols and reports two things. The first is whether the descrambler has locked, which it decides by counting an unbroken run of idle symbols. The second is whether the link partner is jabbering, which it decides by timing how long the stream has been busy without a break. A jabber condition drives a carrier-sense contribution high. That contribution stays high until lock has been regained, and then it falls once, cleanly.

A microsecond tick from elsewhere on the chip paces the busy-time limit. Each symbol arrives with a valid strobe and a flag that marks it as idle. A link-test-fail input clears all state and holds lock low. When a frame ends close to the limit, the block must not produce a stray carrier pulse. A single idle symbol closes the busy window at once, so the frame end wins even when that idle arrives in the same cycle as the final tick.

Top module: `rx_sync_jabber_mon`

## Requirements
- R1: After reset, cipher_sync, jabber and crs_jab are all 0.
- R2: cipher_sync rises at the clock edge that samples the 15th consecutive valid idle symbol (sym_valid=1, sym_is_idle=1) after link_fail went low. It is still 0 after the 14th.
- R3: A valid non-idle symbol (sym_valid=1, sym_is_idle=0) restarts the idle run from zero. After such a break, 15 further idles are needed before cipher_sync rises.
- R4: Once set, cipher_sync stays 1 through normal frames (valid non-idle symbols) that do not reach the busy limit.
- R5: While link_fail is 1, cipher_sync, jabber and crs_jab are 0 from the next edge on. Both the idle run and the busy timer are cleared, so busy time counted before link_fail never leads to jabber afterwards.
- R6: A valid non-idle symbol that follows idle opens a busy window. jabber rises at the edge that samples the 722nd us_tick inside that window, and it stays 0 after the 721st. crs_jab equals jabber at all times, and cipher_sync drops at the same edge that jabber rises.
- R7: The busy timer restarts from zero on every idle-to-busy transition. Two windows of 700 ticks each, separated by one idle symbol, do not raise jabber.
- R8: A valid idle symbol closes the busy window and clears the timer. This holds even when it is sampled in the same cycle as the tick that would otherwise be the 722nd, and in that case jabber stays 0.
- R9: jabber holds until a run of 15 consecutive idle symbols. A non-idle symbol inside the run restarts it. jabber falls and cipher_sync rises at the edge that samples the 15th idle, and crs_jab does not toggle before then.
- R10: Ticks that arrive while the stream is idle are not counted. A later frame still needs the full 722 ticks to raise jabber.
- R11: Ticks inside a busy window are counted whether or not a symbol is valid in the same cycle.
- R12: Cycles with sym_valid=0 are ignored whatever sym_is_idle holds. Such cycles neither extend an idle run nor open a busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_is_idle | input | 1 | The present symbol is an idle symbol |
| link_fail | input | 1 | Link test failing; clears all state |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cipher_sync | output | 1 | Descrambler lock indication |
| jabber | output | 1 | Busy-time limit exceeded |
| crs_jab | output | 1 | Carrier-sense contribution held by jabber |

## Verification
Two functions can meet in a single cycle. One is the end of a frame, when the first idle symbol closes the busy window. The other is expiry of the busy timer on its final microsecond tick. The bench opens a window, delivers 721 ticks, and then presents an idle symbol and the last tick in the same cycle. It judges the result by requiring that jabber and crs_jab stay 0 while cipher_sync stays 1. A neighbouring case repeats the run with the idle symbol arriving one cycle after the 721st tick and no final tick, which again must not raise jabber.

// File: rtl/rsjm_pkg.sv
// Package: shared defaults and the receive-state encoding for the
// cipher-lock / jabber guard. Assumes nothing beyond IEEE 1800-2017.
package rsjm_pkg;

    // Number of consecutive idle symbols that declares lock.
    parameter int unsigned DEF_IDLE_RUN   = 15;
    // Busy-window limit expressed in microsecond ticks.
    parameter int unsigned DEF_TIMEOUT_US = 722;

    // Receive stream state as seen by the guard.
    typedef enum logic [1:0] {
        RX_QUIET  = 2'd0,   // stream idle, no busy window open
        RX_BUSY   = 2'd1,   // busy window open, timer running
        RX_JABBER = 2'd2    // limit exceeded, waiting for resync
    } rx_state_e;

endpackage

// File: rtl/rsjm_idle_run.sv
// Module: rsjm_idle_run
// Counts consecutive valid idle symbols and saturates at IDLE_RUN.
// A valid non-idle symbol or the clear input resets the run. Cycles
// without a valid symbol hold the count. The module publishes whether
// the count after this edge equals the target, so that the consumer
// can act at the same edge that samples the final idle.
// Assumes: clr has priority over symbols.
module rsjm_idle_run #(
    parameter int unsigned IDLE_RUN = rsjm_pkg::DEF_IDLE_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic idle_sym,
    input  logic data_sym,
    output logic run_full_next
);
    localparam int unsigned CW = $clog2(IDLE_RUN + 1);
    localparam logic [CW-1:0] TARGET = CW'(IDLE_RUN);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Next-count selection: clear, saturating increment, break, or hold.
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (idle_sym) begin
            if (cnt_q != TARGET) begin
                cnt_d = cnt_q + CW'(1);
            end
        end else if (data_sym) begin
            cnt_d = '0;
        end
    end

    // Run-length register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Target reached by the count that this edge will store.
    assign run_full_next = (cnt_d == TARGET);

endmodule

// File: rtl/rsjm_busy_timer.sv
// Module: rsjm_busy_timer
// Counts microsecond ticks while a busy window is open and flags expiry
// on the tick that completes TIMEOUT_US. The count is zero whenever the
// window is closed, and it restarts on the window-open pulse.
// Assumes: the controller closes the window at or after expiry, so the
// count never needs to pass TIMEOUT_US-1.
module rsjm_busy_timer #(
    parameter int unsigned TIMEOUT_US = rsjm_pkg::DEF_TIMEOUT_US
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic open_win,
    input  logic running,
    input  logic tick,
    output logic expire
);
    localparam int unsigned TW = $clog2(TIMEOUT_US + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_US - 1);

    logic [TW-1:0] tmr_q;
    logic [TW-1:0] tmr_d;

    // Next-count selection: zero when closed or restarting, else count ticks.
    always_comb begin
        tmr_d = tmr_q;
        if (clr || open_win || !running) begin
            tmr_d = '0;
        end else if (tick && (tmr_q != LAST)) begin
            tmr_d = tmr_q + TW'(1);
        end
    end

    // Elapsed-time register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // Expiry: the tick that would complete the limit inside an open window.
    assign expire = running && !clr && tick && (tmr_q == LAST);

endmodule

// File: rtl/rsjm_rx_ctrl.sv
// Module: rsjm_rx_ctrl
// Receive-state controller. It opens a busy window on the first data
// symbol after idle and closes it on any idle symbol. An idle symbol
// beats a same-cycle expiry, so a frame ending at the limit causes no
// jabber. On expiry it enters jabber, which drops lock. Jabber is left
// only when a full idle run completes, and lock returns at that same
// edge. Outputs are registered, so carrier contribution cannot glitch.
// Assumes: link_fail clears everything with top priority.
module rsjm_rx_ctrl
    import rsjm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_fail,
    input  logic idle_sym,
    input  logic data_sym,
    input  logic run_full_next,
    input  logic expire,
    output logic open_win,
    output logic running,
    output logic sync_q,
    output logic jab_q
);
    rx_state_e st_q;
    rx_state_e st_d;
    logic      sync_d;

    // State transition and window-open decision.
    always_comb begin
        st_d     = st_q;
        open_win = 1'b0;
        if (link_fail) begin
            st_d = RX_QUIET;
        end else begin
            unique case (st_q)
                RX_QUIET: begin
                    if (data_sym) begin
                        st_d     = RX_BUSY;
                        open_win = 1'b1;
                    end
                end
                RX_BUSY: begin
                    if (idle_sym) begin
                        st_d = RX_QUIET;
                    end else if (expire) begin
                        st_d = RX_JABBER;
                    end
                end
                RX_JABBER: begin
                    if (run_full_next) begin
                        st_d = RX_QUIET;
                    end
                end
                default: st_d = RX_QUIET;
            endcase
        end
    end

    // Lock decision: cleared by link failure or jabber entry, set by a full run.
    always_comb begin
        sync_d = sync_q;
        if (link_fail) begin
            sync_d = 1'b0;
        end else if ((st_q == RX_BUSY) && (st_d == RX_JABBER)) begin
            sync_d = 1'b0;
        end else if (run_full_next) begin
            sync_d = 1'b1;
        end
    end

    // State, lock and jabber registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_QUIET;
            sync_q <= 1'b0;
            jab_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            sync_q <= sync_d;
            jab_q  <= (st_d == RX_JABBER);
        end
    end

    assign running = (st_q == RX_BUSY);

endmodule

// File: rtl/rx_sync_jabber_mon.sv
// Module: rx_sync_jabber_mon (top)
// Cipher-lock detection from idle runs plus the busy-time jabber guard
// for a 100 Mb/s receive symbol stream. The top module qualifies the
// symbol strobes and wires the idle-run counter, the busy timer and
// the receive controller together.
// Assumes: us_tick is a single-cycle pulse; all inputs are synchronous to clk.
module rx_sync_jabber_mon #(
    parameter int unsigned IDLE_RUN   = rsjm_pkg::DEF_IDLE_RUN,
    parameter int unsigned TIMEOUT_US = rsjm_pkg::DEF_TIMEOUT_US
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_is_idle,
    input  logic link_fail,
    input  logic us_tick,
    output logic cipher_sync,
    output logic jabber,
    output logic crs_jab
);
    logic idle_sym;
    logic data_sym;
    logic run_full_next;
    logic expire;
    logic open_win;
    logic running;
    logic sync_q;
    logic jab_q;

    // Symbol qualification: only valid symbols count.
    assign idle_sym = sym_valid && sym_is_idle;
    assign data_sym = sym_valid && !sym_is_idle;

    rsjm_idle_run #(
        .IDLE_RUN (IDLE_RUN)
    ) u_idle_run (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (link_fail),
        .idle_sym      (idle_sym),
        .data_sym      (data_sym),
        .run_full_next (run_full_next)
    );

    rsjm_busy_timer #(
        .TIMEOUT_US (TIMEOUT_US)
    ) u_busy_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (link_fail),
        .open_win (open_win),
        .running  (running),
        .tick     (us_tick),
        .expire   (expire)
    );

    rsjm_rx_ctrl u_rx_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_fail     (link_fail),
        .idle_sym      (idle_sym),
        .data_sym      (data_sym),
        .run_full_next (run_full_next),
        .expire        (expire),
        .open_win      (open_win),
        .running       (running),
        .sync_q        (sync_q),
        .jab_q         (jab_q)
    );

    assign cipher_sync = sync_q;
    assign jabber      = jab_q;
    assign crs_jab     = jab_q;

endmodule

// File: rtl/rx_sync_jabber_mon_chk.sv
// Module: rx_sync_jabber_mon_chk
// Port-level checker for rx_sync_jabber_mon, attached with bind below.
module rx_sync_jabber_mon_chk (
    input logic clk,
    input logic rst_n,
    input logic sym_valid,
    input logic sym_is_idle,
    input logic link_fail,
    input logic us_tick,
    input logic cipher_sync,
    input logic jabber,
    input logic crs_jab
);
    // Carrier contribution tracks jabber exactly.
    assert_crs_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crs_jab == jabber);

    // Link failure clears lock and jabber at the next edge.
    assert_linkfail_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail |=> (!cipher_sync && !jabber));

    // Lock only ever rises on a sampled valid idle symbol.
    assert_sync_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cipher_sync) |-> $past(sym_valid && sym_is_idle));

    // Jabber starts only on a tick and drops lock with it.
    assert_jab_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jabber) |-> ($past(us_tick) && !cipher_sync));

    // An idle symbol never lets jabber start at the next edge.
    assert_idle_blocks_jab_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!jabber && sym_valid && sym_is_idle) |=> !jabber);

    // Jabber ends with lock restored, unless link failure ended it.
    assert_jab_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jabber) |-> (cipher_sync || $past(link_fail)));

    // Empty cycles without tick or link failure change no output.
    assert_empty_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !us_tick && !link_fail) |=> ($stable(cipher_sync) && $stable(jabber)));

endmodule

bind rx_sync_jabber_mon rx_sync_jabber_mon_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid   (sym_valid),
    .sym_is_idle (sym_is_idle),
    .link_fail   (link_fail),
    .us_tick     (us_tick),
    .cipher_sync (cipher_sync),
    .jabber      (jabber),
    .crs_jab     (crs_jab)
);

// File: tb/rx_sync_jabber_mon_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module rx_sync_jabber_mon_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0;
    logic sym_is_idle = 1'b0;
    logic link_fail = 1'b0;
    logic us_tick = 1'b0;
    logic cipher_sync;
    logic jabber;
    logic crs_jab;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    rx_sync_jabber_mon dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid   (sym_valid),
        .sym_is_idle (sym_is_idle),
        .link_fail   (link_fail),
        .us_tick     (us_tick),
        .cipher_sync (cipher_sync),
        .jabber      (jabber),
        .crs_jab     (crs_jab)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // One cycle of stimulus, driven at a falling edge; returns at the next one.
    task automatic step(input logic v, input logic idl, input logic tk, input logic lf);
        sym_valid   = v;
        sym_is_idle = idl;
        us_tick     = tk;
        link_fail   = lf;
        @(negedge clk);
        sym_valid   = 1'b0;
        sym_is_idle = 1'b0;
        us_tick     = 1'b0;
        link_fail   = 1'b0;
    endtask

    task automatic idles(input int n);
        repeat (n) step(1'b1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        repeat (n) step(1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic data_sym();
        step(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic relock();
        step(1'b0, 1'b0, 1'b0, 1'b1);
        idles(15);
    endtask

    task automatic t_reset();
        chk("R1", "cipher_sync after reset", cipher_sync, 1'b0);
        chk("R1", "jabber after reset", jabber, 1'b0);
        chk("R1", "crs_jab after reset", crs_jab, 1'b0);
    endtask

    task automatic t_sync_count();
        step(1'b0, 1'b0, 1'b0, 1'b1);
        idles(14);
        chk("R2", "sync after 14 idles", cipher_sync, 1'b0);
        idles(1);
        chk("R2", "sync after 15 idles", cipher_sync, 1'b1);
    endtask

    task automatic t_run_break();
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5", "sync after link_fail", cipher_sync, 1'b0);
        idles(14);
        data_sym();
        idles(14);
        chk("R3", "sync 14 idles after break", cipher_sync, 1'b0);
        idles(1);
        chk("R3", "sync 15 idles after break", cipher_sync, 1'b1);
    endtask

    task automatic t_sticky();
        logic held = 1'b1;
        repeat (5) begin
            data_sym();
            if (cipher_sync !== 1'b1) held = 1'b0;
        end
        ticks(100);
        idles(1);
        chk("R4", "sync held across frame", held & cipher_sync, 1'b1);
        chk("R4", "no jabber on short frame", jabber, 1'b0);
    endtask

    task automatic t_timeout_and_release();
        logic crs_steady = 1'b1;
        data_sym();
        ticks(721);
        chk("R6", "jabber after 721 ticks", jabber, 1'b0);
        ticks(1);
        chk("R6", "jabber after 722 ticks", jabber, 1'b1);
        chk("R6", "crs_jab at timeout", crs_jab, 1'b1);
        chk("R6", "sync dropped at timeout", cipher_sync, 1'b0);
        // R9: partial runs and a break must not release jabber
        repeat (14) begin
            idles(1);
            if (crs_jab !== 1'b1) crs_steady = 1'b0;
        end
        data_sym();
        repeat (14) begin
            idles(1);
            if (crs_jab !== 1'b1) crs_steady = 1'b0;
        end
        chk("R9", "crs_jab steady before resync", crs_steady, 1'b1);
        chk("R9", "sync low before resync", cipher_sync, 1'b0);
        idles(1);
        chk("R9", "jabber released on 15th idle", jabber, 1'b0);
        chk("R9", "crs_jab released on 15th idle", crs_jab, 1'b0);
        chk("R9", "sync restored on 15th idle", cipher_sync, 1'b1);
    endtask

    task automatic t_restart();
        data_sym();
        ticks(700);
        idles(1);
        data_sym();
        ticks(700);
        chk("R7", "no jabber after two 700-tick windows", jabber, 1'b0);
        ticks(22);
        chk("R7", "jabber 722 ticks into second window", jabber, 1'b1);
        idles(15);
    endtask

    task automatic t_race();
        data_sym();
        ticks(721);
        step(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R8", "no jabber with idle on final tick", jabber, 1'b0);
        ticks(3);
        chk("R8", "crs_jab quiet after race", crs_jab, 1'b0);
        chk("R8", "sync kept after race", cipher_sync, 1'b1);
        data_sym();
        ticks(721);
        idles(1);
        ticks(5);
        chk("R8", "no jabber when frame ends after 721 ticks", jabber, 1'b0);
    endtask

    task automatic t_quiet_ticks();
        ticks(1000);
        chk("R10", "no jabber from idle ticks", jabber, 1'b0);
        data_sym();
        ticks(721);
        chk("R10", "full window still needed", jabber, 1'b0);
        // R11: a tick with a valid data symbol still counts
        step(1'b1, 1'b0, 1'b1, 1'b0);
        chk("R11", "tick with data symbol counted", jabber, 1'b1);
        idles(15);
    endtask

    task automatic t_link();
        data_sym();
        ticks(722);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5", "jabber cleared by link_fail", jabber, 1'b0);
        chk("R5", "crs_jab cleared by link_fail", crs_jab, 1'b0);
        chk("R5", "sync low under link_fail", cipher_sync, 1'b0);
        relock();
        data_sym();
        ticks(700);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        ticks(800);
        chk("R5", "busy time discarded by link_fail", jabber, 1'b0);
        idles(14);
        chk("R5", "idle run restarted by link_fail", cipher_sync, 1'b0);
    endtask

    task automatic t_ignore();
        step(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (20) step(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R12", "invalid idles do not lock", cipher_sync, 1'b0);
        idles(15);
        repeat (10) step(1'b0, 1'b0, 1'b0, 1'b0);
        ticks(800);
        chk("R12", "invalid data opens no window", jabber, 1'b0);
        chk("R12", "sync kept through invalid cycles", cipher_sync, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync_count();
        t_run_break();
        t_sticky();
        t_timeout_and_release();
        t_restart();
        t_race();
        t_quiet_ticks();
        t_link();
        t_ignore();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule